// File: doc/BRIEF.md
# Receive Frame Padder and Status Prefixer

The block sits behind an Ethernet receive path. It takes one frame at a time as a byte stream, each byte marked valid, with a start marker on the first byte and an end marker on the last. It stores the frame in a local buffer. It then sends the frame onward behind a 4-byte prefix that holds a 16-bit status word and the frame's padded length. Both prefix fields are little-endian.

Padding has two steps. First, a short frame is zero-filled up to the minimum length. Second, one to four zero bytes are added to reach the next 4-byte boundary, and a frame already on a boundary still gains four bytes. The status word reports receive-OK. It also reports whether the destination address is the all-ones broadcast address, or the programmed station address.

The prefix depends on the final length and on the address results, so no byte leaves before the end marker has arrived. The output uses a valid/ready handshake, and a one-cycle pulse marks the end of each emitted frame. Frames that begin while reception is not armed are dropped whole.

Top module: `rx_frame_prefixer`

## Requirements
- R1: After reset, `out_valid` and `out_done` are low and `in_ready` is high.
- R2: With stored length n, let m = 60 if n < 60, else m = n. The padded length is m + 4 - (m mod 4). It is carried in the length field, which does not count the 4 prefix bytes. The block emits exactly padded length + 4 bytes.
- R3: The emitted order is: status bits 7:0, status bits 15:8, length bits 7:0, length bits 15:8, then the n stored frame bytes in arrival order, then zero bytes up to the padded length.
- R4: Status bit 0 is always 1. Every status bit other than 0, 13 and 14 is always 0.
- R5: Status bit 13 is 1 exactly when the first six frame bytes are all 8'hFF.
- R6: Status bit 14 is 1 exactly when each frame byte k, for k = 0 to 5, equals `station_addr[8k+7:8k]`.
- R7: A frame with fewer than six bytes sets neither bit 13 nor bit 14.
- R8: A frame whose start byte is accepted while `rx_armed` is low produces no output at all, up to and including its end byte. The next armed frame is emitted normally.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values, and no byte is lost.
- R10: `in_ready` is low while a frame is being emitted. `out_done` is high for exactly one cycle, in the cycle after the final byte transfer, and `out_valid` is low in that cycle.
- R11: Bytes past the first DEPTH bytes of a frame are discarded. Length and padding are then computed with n = DEPTH.
- R12: In the idle state, bytes without a start marker are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| station_addr | input | 48 | Station address; byte k is bits 8k+7:8k |
| rx_armed | input | 1 | Reception armed (receive buffer base programmed) |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a frame |
| in_eop | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept an input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_done | output | 1 | One-cycle pulse after the last byte of a frame is sent |

## Verification
The two events that can fall in the same cycle are the address comparison on the first byte and the end of the frame. A one-byte frame carries both the start and end markers, so the comparator must clear and update, and the state must jump straight to emitting, on a single edge. The bench sweeps every frame length from 1 to 70, which provokes this case along with every remainder of the alignment step. Each length is judged against a padded length computed in the bench. Random backpressure is applied on alternate frames, so the final transfer and the done pulse land after stalls of varied length.

// File: rtl/rxpad_pkg.sv
package rxpad_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_SKIP = 2'd2,
        RX_SEND = 2'd3
    } rx_state_e;

    localparam int STAT_OK_BIT    = 0;
    localparam int STAT_BCAST_BIT = 13;
    localparam int STAT_STA_BIT   = 14;
    localparam int MIN_FILL       = 60;
    localparam int ADDR_BYTES     = 6;
    localparam int PREFIX_BYTES   = 4;
endpackage

// File: rtl/rxpad_len_calc.sv
module rxpad_len_calc #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] raw_len,
    output logic [CNT_W-1:0] pad_len
);
    import rxpad_pkg::*;

    logic [CNT_W-1:0] min_len;

    always_comb begin
        min_len = (raw_len < CNT_W'(MIN_FILL)) ? CNT_W'(MIN_FILL) : raw_len;
        // clearing the low two bits and adding four gives m + 4 - (m mod 4)
        pad_len = {min_len[CNT_W-1:2], 2'b00} + CNT_W'(4);
    end
endmodule

// File: rtl/rxpad_addr_cmp.sv
module rxpad_addr_cmp #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic             cmp_clear,
    input  logic [CNT_W-1:0] cmp_idx,
    input  logic [7:0]       cmp_byte,
    input  logic [47:0]      station_addr,
    output logic             bcast_hit,
    output logic             sta_hit
);
    import rxpad_pkg::*;

    typedef struct packed {
        logic bc;
        logic st;
    } cmp_s;

    cmp_s c_d, c_q;
    logic base_bc, base_st;
    logic [2:0] sel;

    always_comb begin
        c_d     = c_q;
        base_bc = cmp_clear ? 1'b1 : c_q.bc;
        base_st = cmp_clear ? 1'b1 : c_q.st;
        sel     = cmp_idx[2:0];
        if (cmp_en && (cmp_idx < CNT_W'(ADDR_BYTES))) begin
            c_d.bc = base_bc && (cmp_byte == 8'hFF);
            c_d.st = base_st && (cmp_byte == station_addr[sel*8 +: 8]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign bcast_hit = c_q.bc;
    assign sta_hit   = c_q.st;

    // R5: once a byte mismatches, the broadcast flag stays low until the next frame start
    a_r5_bcast_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.bc && !cmp_clear) |=> !c_q.bc);
endmodule

// File: rtl/rxpad_store.sv
module rxpad_store #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_byte;
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/rx_frame_prefixer.sv
module rx_frame_prefixer #(
    parameter int DEPTH = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] station_addr,
    input  logic        rx_armed,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_done
);
    import rxpad_pkg::*;

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 128);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
        logic             done;
    } ctl_s;

    ctl_s r_d, r_q;

    logic              take;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              cmp_en, cmp_clear;
    logic [CNT_W-1:0]  cmp_idx;
    logic              bcast_hit, sta_hit;
    logic [CNT_W-1:0]  pad_len;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  body_idx;
    logic              body_live;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_byte;
    logic [15:0]       status_w;
    logic [15:0]       len_w;
    logic              long_enough;

    rxpad_len_calc #(.CNT_W(CNT_W)) u_len (
        .raw_len (r_q.cnt),
        .pad_len (pad_len)
    );

    rxpad_addr_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_en       (cmp_en),
        .cmp_clear    (cmp_clear),
        .cmp_idx      (cmp_idx),
        .cmp_byte     (in_data),
        .station_addr (station_addr),
        .bcast_hit    (bcast_hit),
        .sta_hit      (sta_hit)
    );

    rxpad_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_byte (in_data),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    assign in_ready = (r_q.st != RX_SEND);
    assign take     = in_valid && in_ready;
    assign last_idx = pad_len + CNT_W'(PREFIX_BYTES - 1);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = ADDR_W'(r_q.cnt);
        cmp_en    = 1'b0;
        cmp_clear = 1'b0;
        cmp_idx   = r_q.cnt;
        unique case (r_q.st)
            RX_IDLE: begin
                if (take && in_sop) begin
                    if (rx_armed) begin
                        wr_en     = 1'b1;
                        wr_addr   = '0;
                        cmp_en    = 1'b1;
                        cmp_clear = 1'b1;
                        cmp_idx   = '0;
                        r_d.cnt   = CNT_W'(1);
                        r_d.idx   = '0;
                        r_d.st    = in_eop ? RX_SEND : RX_FILL;
                    end else begin
                        r_d.st = in_eop ? RX_IDLE : RX_SKIP;
                    end
                end
            end
            RX_FILL: begin
                if (take) begin
                    if (r_q.cnt < CNT_W'(DEPTH)) begin
                        wr_en   = 1'b1;
                        cmp_en  = 1'b1;
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                    if (in_eop) r_d.st = RX_SEND;
                end
            end
            RX_SKIP: begin
                if (take && in_eop) r_d.st = RX_IDLE;
            end
            RX_SEND: begin
                if (out_ready) begin
                    if (r_q.idx == last_idx) begin
                        r_d.st   = RX_IDLE;
                        r_d.idx  = '0;
                        r_d.cnt  = '0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + CNT_W'(1);
                    end
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= RX_IDLE;
            r_q.cnt  <= '0;
            r_q.idx  <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // output byte selection
    always_comb begin
        long_enough = (r_q.cnt >= CNT_W'(ADDR_BYTES));
        status_w    = '0;
        status_w[STAT_OK_BIT]    = 1'b1;
        status_w[STAT_BCAST_BIT] = bcast_hit && long_enough;
        status_w[STAT_STA_BIT]   = sta_hit && long_enough;
        len_w     = 16'(pad_len);
        body_idx  = r_q.idx - CNT_W'(PREFIX_BYTES);
        body_live = (body_idx < r_q.cnt);
        rd_addr   = body_live ? ADDR_W'(body_idx) : '0;
        unique case (r_q.idx)
            CNT_W'(0): out_data = status_w[7:0];
            CNT_W'(1): out_data = status_w[15:8];
            CNT_W'(2): out_data = len_w[7:0];
            CNT_W'(3): out_data = len_w[15:8];
            default:   out_data = body_live ? rd_byte : 8'h00;
        endcase
    end

    assign out_valid = (r_q.st == RX_SEND);
    assign out_done  = r_q.done;

    // R9: a stalled byte is held
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R10: done only follows a transfer
    a_r10_done_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> ($past(out_valid && out_ready) && !out_valid));
    // R10: no input accepted while emitting
    a_r10_no_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R2: the padded length is aligned and at least the minimum size
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((pad_len[1:0] == 2'b00) && (pad_len >= CNT_W'(64))));
    // R11: the stored count never passes the buffer depth
    a_r11_cap: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: tb/rx_frame_prefixer_tb.sv
module rx_frame_prefixer_tb_top;
    localparam int DEPTH = 80;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] station_addr;
    logic        rx_armed;
    logic        in_valid, in_sop, in_eop;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        out_valid, out_ready, out_done;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    rx_frame_prefixer #(.DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .station_addr (station_addr),
        .rx_armed     (rx_armed),
        .in_valid     (in_valid),
        .in_sop       (in_sop),
        .in_eop       (in_eop),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_done     (out_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit bp_on = 1'b0;
    logic [7:0] fb [0:127];
    logic [7:0] gb [0:255];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input int n, input bit with_sop);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[i];
            in_sop   = with_sop && (i == 0);
            in_eop   = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        int ne, m, pl, got, guard, bad;
        bit bc, st, pstall;
        logic [7:0] pdata;
        logic [15:0] stat;
        ne = (n > DEPTH) ? DEPTH : n;
        m  = (ne < 60) ? 60 : ne;
        pl = m + 4 - (m % 4);
        bc = (ne >= 6);
        st = (ne >= 6);
        for (int k = 0; k < 6; k++) begin
            if (fb[k] != 8'hFF) bc = 1'b0;
            if (fb[k] != station_addr[8*k +: 8]) st = 1'b0;
        end
        stat = 16'h0001 | (16'(bc) << 13) | (16'(st) << 14);
        send(n, 1'b1);
        chk(out_valid && !in_ready, $sformatf("R10 in_ready low while sending (%s)", tag),
            {30'd0, out_valid, in_ready}, 2);
        got = 0; guard = 0; pstall = 1'b0; pdata = '0;
        while (got < pl + 4 && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (pstall)
                chk(out_valid && out_data == pdata, $sformatf("R9 held byte (%s)", tag),
                    out_data, pdata);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_on ? (lfsr[0] | lfsr[1]) : 1'b1;
            if (out_valid && out_ready) begin
                gb[got] = out_data;
                got++;
                pstall = 1'b0;
            end else begin
                pstall = out_valid;
                pdata  = out_data;
            end
        end
        chk(got == pl + 4, $sformatf("R2 byte count (%s)", tag), got, pl + 4);
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_done && !out_valid, $sformatf("R10 done pulse (%s)", tag), out_done, 1);
        chk({gb[1], gb[0]} == stat, $sformatf("R4 status word (%s)", tag), {gb[1], gb[0]}, stat);
        chk({gb[3], gb[2]} == 16'(pl), $sformatf("R2 length field (%s)", tag), {gb[3], gb[2]}, pl);
        bad = -1;
        for (int j = 0; j < pl; j++) begin
            logic [7:0] e;
            e = (j < ne) ? fb[j] : 8'h00;
            if (gb[4 + j] !== e && bad < 0) bad = j;
        end
        chk(bad < 0, $sformatf("R3 body bytes, first bad index (%s)", tag), bad, -1);
        @(negedge clk);
        chk(!out_done, $sformatf("R10 done width (%s)", tag), out_done, 0);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid || out_done) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        rx_armed = 1'b1;
        station_addr = 48'h665544332211;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_done && in_ready, "R1 reset state",
            {29'd0, out_valid, out_done, in_ready}, 1);

        // R2/R3/R4: sweep of lengths, alternating backpressure
        for (int n = 1; n <= 70; n++) begin
            for (int i = 0; i < 128; i++) fb[i] = 8'((i * 7 + n * 3 + 1) & 8'hFF);
            bp_on = n[0];
            run(n, $sformatf("R2 sweep n=%0d", n));
        end

        // R5 broadcast
        bp_on = 1'b1;
        for (int i = 0; i < 128; i++) fb[i] = 8'(i + 9);
        for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
        run(6, "R5 broadcast n=6");
        run(64, "R5 broadcast n=64");
        fb[4] = 8'hFE;
        run(30, "R5 broadcast one byte off");

        // R6 station
        for (int k = 0; k < 6; k++) fb[k] = station_addr[8*k +: 8];
        run(60, "R6 station n=60");
        run(61, "R6 station n=61");
        fb[5] = 8'h67;
        run(20, "R6 station partial");

        // R7 short frames
        for (int k = 0; k < 6; k++) fb[k] = station_addr[8*k +: 8];
        run(5, "R7 short station");
        for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
        run(3, "R7 short broadcast");

        // R11 overflow
        for (int i = 0; i < 128; i++) fb[i] = 8'(i * 5 + 2);
        run(90, "R11 overflow n=90");
        run(DEPTH, "R11 exact depth");

        // R8 unarmed frame dropped
        rx_armed = 1'b0;
        for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
        send(20, 1'b1);
        rx_armed = 1'b1;
        quiet(40, "R8 unarmed frame produced output");
        run(10, "R8 next armed frame");

        // R12 bytes without start marker ignored
        send(8, 1'b0);
        quiet(30, "R12 stray bytes produced output");
        run(12, "R12 following frame");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule